// File: doc/BRIEF.md
# Framed Serial Port Receiver

This block receives fixed-length data elements from a synchronous serial link made of three pins: a serial clock, a frame sync and a data line. All logic runs on a fast system clock. The serial pins are synchronised into that domain, and the rising and falling edges of the serial clock are found by comparing successive samples. Serial data is sampled on falling edges. A frame sync seen high on a falling edge starts an element. A programmable delay of 0, 1 or 2 bit periods passes before the first bit, and the bits are then shifted in most significant bit first.

Each finished element passes through two storage stages before software sees it. The shift register hands the element to a receive buffer on the next rising serial clock edge, and only does so if the buffer is empty. The buffer then moves the element into the readable data register on a falling serial clock edge, and only when that register has been read. That move raises a ready flag for a host or DMA engine, and a one-cycle read strobe lowers it again. When an element completes while the buffer is still occupied, the element is discarded and a sticky overrun flag records the loss until software clears it.

Top module: `fsp_rx`

## Requirements
- R1: After reset, ready_o and ovf_o are 0 and data_o is all zeros.
- R2: A frame sync is recognised when fsync_i is high at a falling edge of sclk_i and no element is in progress. The element holds ELEM_W bits (8 by default), sampled from sdata_i on falling edges, with the first sampled bit landing in bit ELEM_W-1 of data_o.
- R3: delay_i selects how many falling edges pass between recognition and the first data bit. Code 0 samples the first bit on the recognising edge itself, code 1 on the next falling edge, and code 2 on the falling edge after that. Code 3 behaves like code 2.
- R4: ready_o does not rise on the falling edge that samples an element's last bit. The element enters the buffer on the following rising edge, and ready_o rises on the falling edge after that, provided the data register is free.
- R5: A one-cycle pulse on rd_i while ready_o is 1 clears ready_o at the next system clock edge. data_o does not change while ready_o is 1, and a read leaves it unchanged.
- R6: An element that reaches the buffer while ready_o is 1 stays in the buffer. It is moved to data_o, and ready_o is set, on the first falling sclk_i edge after the read.
- R7: If the buffer is still full when a new element completes, that element is dropped and ovf_o is set. ovf_o stays 1 until a pulse on ovf_clr_i, and a new overrun in the same cycle as a clear wins.
- R8: A frame sync that is high on a falling edge while an element is being received has no effect on that element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial receive clock, asynchronous to clk |
| fsync_i | input | 1 | Frame sync, active high |
| sdata_i | input | 1 | Serial data |
| delay_i | input | 2 | Data delay code: 0, 1, 2 (3 acts as 2) |
| rd_i | input | 1 | Read strobe for the data register |
| ovf_clr_i | input | 1 | Clears the overrun flag |
| data_o | output | ELEM_W | Data register |
| ready_o | output | 1 | Data register holds an unread element |
| ovf_o | output | 1 | Sticky overrun flag |

## Verification
A change on sclk_i reaches the edge detector after two synchroniser flops and one history flop. The shift state, buffer, data register and ready flag therefore update on the third system clock edge after the serial pin moves. The bench holds each serial clock level for eight system cycles and samples only at the end of a half period, so every expected value has settled well before it is read. A read strobe or overrun clear acts at the next system edge, and the bench checks it two cycles later. Expected data comes from the bench's own bit layout for each delay code; values and delays are swept, and the overrun and buffer-handoff sequences are driven by hand.

// File: rtl/fsp_rx_pkg.sv
package fsp_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } rx_state_e;

    localparam int unsigned MAX_DELAY = 2;

endpackage

// File: rtl/fsp_rx_sync.sv
module fsp_rx_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic fsync_i,
    input  logic sdata_i,
    output logic fall_p,
    output logic rise_p,
    output logic fsync_s,
    output logic sdata_s
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][2:0] chain;
        logic                        prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = {sdata_i, fsync_i, sclk_i};
        for (int i = 1; i < SYNC_STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[LAST][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fall_p  =  s_q.prev & ~s_q.chain[LAST][0];
    assign rise_p  = ~s_q.prev &  s_q.chain[LAST][0];
    assign fsync_s =  s_q.chain[LAST][1];
    assign sdata_s =  s_q.chain[LAST][2];
endmodule

// File: rtl/fsp_rx_shift.sv
module fsp_rx_shift
    import fsp_rx_pkg::*;
#(
    parameter int unsigned ELEM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_p,
    input  logic              rise_p,
    input  logic              fsync_s,
    input  logic              sdata_s,
    input  logic [1:0]        delay_i,
    output logic              push_o,
    output logic [ELEM_W-1:0] elem_o
);
    localparam int unsigned CNT_W = $clog2(ELEM_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ELEM_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [1:0]        dcnt;
        logic [CNT_W-1:0]  cnt;
        logic [ELEM_W-1:0] rsr;
    } shift_t;

    shift_t s_d, s_q;
    logic [1:0] dly_code;

    assign dly_code = (delay_i > 2'(MAX_DELAY)) ? 2'(MAX_DELAY) : delay_i;

    always_comb begin
        s_d    = s_q;
        push_o = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (fall_p && fsync_s) begin
                    if (dly_code == 2'd0) begin
                        s_d.rsr   = {s_q.rsr[ELEM_W-2:0], sdata_s};
                        s_d.cnt   = CNT_W'(1);
                        s_d.state = ST_SHIFT;
                    end else begin
                        s_d.dcnt  = dly_code;
                        s_d.state = ST_DELAY;
                    end
                end
            end
            ST_DELAY: begin
                if (fall_p) begin
                    if (s_q.dcnt == 2'd1) begin
                        s_d.rsr   = {s_q.rsr[ELEM_W-2:0], sdata_s};
                        s_d.cnt   = CNT_W'(1);
                        s_d.state = ST_SHIFT;
                    end else begin
                        s_d.dcnt  = s_q.dcnt - 2'd1;
                    end
                end
            end
            ST_SHIFT: begin
                if (fall_p) begin
                    s_d.rsr = {s_q.rsr[ELEM_W-2:0], sdata_s};
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                    if (s_q.cnt == LAST_CNT) s_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                if (rise_p) begin
                    push_o    = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign elem_o = s_q.rsr;
endmodule

// File: rtl/fsp_rx_buf.sv
module fsp_rx_buf #(
    parameter int unsigned ELEM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_p,
    input  logic              push_i,
    input  logic [ELEM_W-1:0] elem_i,
    input  logic              rd_i,
    input  logic              ovf_clr_i,
    output logic [ELEM_W-1:0] data_o,
    output logic              ready_o,
    output logic              ovf_o
);
    typedef struct packed {
        logic [ELEM_W-1:0] rbr;
        logic              rbr_full;
        logic [ELEM_W-1:0] drr;
        logic              ready;
        logic              ovf;
    } buf_t;

    buf_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (rd_i && b_q.ready) b_d.ready = 1'b0;
        if (ovf_clr_i)         b_d.ovf   = 1'b0;
        if (fall_p && b_q.rbr_full && !b_q.ready) begin
            b_d.drr      = b_q.rbr;
            b_d.rbr_full = 1'b0;
            b_d.ready    = 1'b1;
        end
        if (push_i) begin
            if (!b_q.rbr_full) begin
                b_d.rbr      = elem_i;
                b_d.rbr_full = 1'b1;
            end else begin
                b_d.ovf      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign data_o  = b_q.drr;
    assign ready_o = b_q.ready;
    assign ovf_o   = b_q.ovf;
endmodule

// File: rtl/fsp_rx.sv
module fsp_rx #(
    parameter int unsigned ELEM_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              fsync_i,
    input  logic              sdata_i,
    input  logic [1:0]        delay_i,
    input  logic              rd_i,
    input  logic              ovf_clr_i,
    output logic [ELEM_W-1:0] data_o,
    output logic              ready_o,
    output logic              ovf_o
);
    logic              sclk_fall;
    logic              sclk_rise;
    logic              fsync_s;
    logic              sdata_s;
    logic              push;
    logic [ELEM_W-1:0] elem;

    fsp_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_i),
        .fsync_i (fsync_i),
        .sdata_i (sdata_i),
        .fall_p  (sclk_fall),
        .rise_p  (sclk_rise),
        .fsync_s (fsync_s),
        .sdata_s (sdata_s)
    );

    fsp_rx_shift #(.ELEM_W(ELEM_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_p  (sclk_fall),
        .rise_p  (sclk_rise),
        .fsync_s (fsync_s),
        .sdata_s (sdata_s),
        .delay_i (delay_i),
        .push_o  (push),
        .elem_o  (elem)
    );

    fsp_rx_buf #(.ELEM_W(ELEM_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_p    (sclk_fall),
        .push_i    (push),
        .elem_i    (elem),
        .rd_i      (rd_i),
        .ovf_clr_i (ovf_clr_i),
        .data_o    (data_o),
        .ready_o   (ready_o),
        .ovf_o     (ovf_o)
    );
endmodule

// File: rtl/fsp_rx_chk.sv
module fsp_rx_chk #(
    parameter int unsigned ELEM_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_i,
    input logic              ovf_clr_i,
    input logic              sclk_fall,
    input logic [ELEM_W-1:0] data_o,
    input logic              ready_o,
    input logic              ovf_o
);
    // R5
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && rd_i) |=> !ready_o);

    // R5
    drr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> $stable(data_o));

    // R4
    ready_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(sclk_fall));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

    // R7
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_o) |-> $past(ovf_clr_i));
endmodule

bind fsp_rx fsp_rx_chk #(.ELEM_W(ELEM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_i      (rd_i),
    .ovf_clr_i (ovf_clr_i),
    .sclk_fall (sclk_fall),
    .data_o    (data_o),
    .ready_o   (ready_o),
    .ovf_o     (ovf_o)
);

// File: tb/fsp_rx_tb.sv
module fsp_rx_tb;
    localparam int W    = 8;
    localparam int HALF = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         fsync = 1'b0;
    logic         sdata = 1'b0;
    logic [1:0]   delay = 2'd0;
    logic         rd = 1'b0;
    logic         ovf_clr = 1'b0;
    logic [W-1:0] data;
    logic         ready;
    logic         ovf;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fsp_rx #(.ELEM_W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .fsync_i   (fsync),
        .sdata_i   (sdata),
        .delay_i   (delay),
        .rd_i      (rd),
        .ovf_clr_i (ovf_clr),
        .data_o    (data),
        .ready_o   (ready),
        .ovf_o     (ovf)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one serial bit period: drive on rise, sampled by design on fall
    task automatic period(input logic fs, input logic sd);
        @(negedge clk);
        sclk = 1'b1; fsync = fs; sdata = sd;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame(input logic [W-1:0] v, input int dly, input int extra_fs);
        for (int p = 0; p < dly + W; p++) begin
            logic b;
            b = (p >= dly) ? v[W-1-(p-dly)] : 1'b0;
            period((p == 0) || (p == extra_fs), b);
        end
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(ready == 1'b0, "R1 ready after reset", ready, 0);
        check(ovf == 1'b0, "R1 ovf after reset", ovf, 0);
        check(data == '0, "R1 data after reset", data, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        period(1'b0, 1'b0);

        // R2 R3 R4 R5 sweep over delay codes and data values
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 8; k++) begin
                logic [W-1:0] v;
                int eff;
                eff = (d == 3) ? 2 : d;
                v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 37 + d * 91 + 5) & 255);
                delay = 2'(d);
                frame(v, eff, -1);
                check(ready == 1'b0, "R4 ready low after last bit", ready, 0);
                period(1'b0, 1'b0);
                check(ready == 1'b1, "R4 ready after handoff", ready, 1);
                check(data == v, (d == 3) ? "R3 code3 data" : "R2 R3 data", data, v);
                pulse_rd();
                check(ready == 1'b0, "R5 read clears ready", ready, 0);
                check(data == v, "R5 data kept after read", data, v);
            end
        end

        // R8 frame sync during reception ignored
        delay = 2'd1;
        frame(8'h3C, 1, 4);
        period(1'b0, 1'b0);
        check(data == 8'h3C, "R8 mid-element sync ignored", data, 8'h3C);
        pulse_rd();

        // R6 R7 buffer handoff and overrun
        delay = 2'd0;
        frame(8'hA1, 0, -1);
        period(1'b0, 1'b0);
        check(data == 8'hA1, "R6 first element", data, 8'hA1);
        frame(8'hB2, 0, -1);
        period(1'b0, 1'b0);
        check(data == 8'hA1, "R6 register held while ready", data, 8'hA1);
        check(ovf == 1'b0, "R7 no overrun yet", ovf, 0);
        frame(8'hC3, 0, -1);
        period(1'b0, 1'b0);
        check(ovf == 1'b1, "R7 overrun set", ovf, 1);
        check(data == 8'hA1, "R7 data unchanged on overrun", data, 8'hA1);
        pulse_rd();
        check(ready == 1'b0, "R5 ready cleared", ready, 0);
        period(1'b0, 1'b0);
        check(ready == 1'b1, "R6 buffered element ready", ready, 1);
        check(data == 8'hB2, "R6 buffered element data", data, 8'hB2);
        pulse_rd();
        period(1'b0, 1'b0);
        check(ready == 1'b0, "R7 dropped element absent", ready, 0);
        check(data == 8'hB2, "R7 data after drop", data, 8'hB2);
        check(ovf == 1'b1, "R7 overrun sticky", ovf, 1);
        pulse_clr();
        check(ovf == 1'b0, "R7 overrun cleared", ovf, 0);

        // R2 back-to-back after overrun cleared
        frame(8'h5E, 0, -1);
        period(1'b0, 1'b0);
        check(data == 8'h5E, "R2 recovery data", data, 8'h5E);
        check(ovf == 1'b0, "R7 no overrun on free buffer", ovf, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule